// File: doc/BRIEF.md
# Calendar alarm comparator with repeat modes

This block watches a running calendar, given as BCD month, day of month, hour, minute and second, and raises an alarm when that time matches a stored alarm setting. A five-bit repeat code decides which calendar fields take part in the comparison. Repeats range from once every second to once per year. The comparison runs once per second, on a one-cycle tick from the calendar counter. A tick with a match sets a sticky alarm flag and, when the interrupt is enabled, drives an active-low interrupt request.

Software writes the settings through a small register strobe interface. A strobe for reading the flags clears the flag and the interrupt. A level input reports that the register pointer rests on the flags location. While that input is high, the interrupt is held off, and it is released once the pointer moves away. A battery-backup input changes the interrupt gating, so that a backup wake-up needs its own enable.

Top module: `alarm_calendar_unit`

## Requirements
- R1: After reset, `alarm_flag_o` is 0, `irq_no` is 1, the control bits are all 0, every alarm field is 0 and the repeat code is 00000.
- R2: On a cycle with `sec_tick_i` high, the repeat code selects the fields that are compared. Code 11111 compares none, so every tick matches. Code 11110 compares the second. Code 11100 compares minute and second. Code 11000 compares hour, minute and second. Code 10000 also compares the day of month. Code 00000 compares all five fields. A match sets `alarm_flag_o` at the clock edge that ends the tick cycle.
- R3: Any repeat code not listed in R2 behaves like 11111, so every tick matches.
- R4: A match always sets the flag. At the same edge, `irq_no` goes low only if the interrupt enable (control bit 0) is 1 and the square-wave enable (control bit 2) is 0.
- R5: A pulse on `flag_rd_i` clears both the flag and the interrupt at the next edge. In the read cycle itself, the flag still shows its set value, so only a later read sees 0. A match in the same cycle as the read wins and sets the flag again.
- R6: While `ptr_at_flag_i` is high, `irq_no` is held at 1 from the next edge onward. A pending interrupt appears at the first edge after the pointer leaves, unless it was cleared in the meantime.
- R7: While `on_battery_i` is high, a match asserts the interrupt only when both the backup enable (control bit 1) and the interrupt enable are 1.
- R8: A matching time produces no flag unless it comes with a tick. After a flag read, no further flag appears without a new matching tick.
- R9: Register select 0 holds the control bits, 1 the alarm second, 2 the minute, 3 the hour, 4 the day of month, 5 the month and 6 the repeat code (bits 4:0). The comparison uses only the BCD bits of each field: 7 bits for second and minute, 6 for hour and day of month, 5 for month. Any bit above those is ignored on both the alarm side and the time side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sec_tick_i | input | 1 | One-cycle pulse for each new second |
| now_sec_i | input | 8 | Current second, BCD |
| now_min_i | input | 8 | Current minute, BCD |
| now_hr_i | input | 8 | Current hour, BCD, 24-hour |
| now_date_i | input | 8 | Current day of month, BCD |
| now_mon_i | input | 8 | Current month, BCD |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select for a write |
| reg_wdata_i | input | 8 | Register write data |
| flag_rd_i | input | 1 | Flags-read strobe |
| ptr_at_flag_i | input | 1 | Register pointer rests on the flags location |
| on_battery_i | input | 1 | Battery-backup mode indication |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
A wrongly decoded repeat code or a dropped field mask shows at the ports as a flag that is missing or spurious. It appears at the first tick whose time differs only in the affected field, which is one cycle after that tick. A pending state that is lost or stuck shows one edge after the pointer leaves the flags location, or one edge after a flags read, as `irq_no` at the wrong level. The bench therefore compares both outputs every cycle against a model, under random tick, time and enable patterns.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned NUM_FIELDS = 5;
  localparam int unsigned RPT_W      = 5;
  localparam int unsigned SEL_W      = 3;

  // field index order used by every packed field array
  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HR   = 2;
  localparam int unsigned F_DATE = 3;
  localparam int unsigned F_MON  = 4;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
  localparam logic [SEL_W-1:0] SEL_RPT  = 3'd6;

  typedef struct packed {
    logic wave_en;
    logic bkp_en;
    logic irq_en;
  } ctrl_t;

  // significant BCD bits per field
  function automatic logic [7:0] field_mask(int unsigned idx);
    case (idx)
      F_SEC, F_MIN:  return 8'h7F;
      F_HR, F_DATE:  return 8'h3F;
      default:       return 8'h1F;
    endcase
  endfunction

  // bit i set when field i takes part in the compare
  function automatic logic [NUM_FIELDS-1:0] compare_set(logic [RPT_W-1:0] code);
    case (code)
      5'b11110: return 5'b00001;
      5'b11100: return 5'b00011;
      5'b11000: return 5'b00111;
      5'b10000: return 5'b01111;
      5'b00000: return 5'b11111;
      default:  return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
  import alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [SEL_W-1:0]                    sel_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output ctrl_t                               ctrl_o,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0]   alarm_o,
  output logic [RPT_W-1:0]                    rpt_o
);
  ctrl_t                             ctrl_q, ctrl_d;
  logic [RPT_W-1:0]                  rpt_q, rpt_d;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_q, alarm_d;
  logic                              unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:RPT_W];

  always_comb begin
    ctrl_d = ctrl_q;
    rpt_d  = rpt_q;
    if (we_i && sel_i == SEL_CTRL) ctrl_d = ctrl_t'(wdata_i[2:0]);
    if (we_i && sel_i == SEL_RPT)  rpt_d  = wdata_i[RPT_W-1:0];
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i + 1);
    always_comb begin
      alarm_d[i] = alarm_q[i];
      if (we_i && sel_i == MY_SEL) alarm_d[i] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rpt_q   <= '0;
      alarm_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      rpt_q   <= rpt_d;
      alarm_q <= alarm_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rpt_o   = rpt_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                              tick_i,
  input  logic [RPT_W-1:0]                  rpt_i,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_i,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] now_i,
  output logic                              hit_o
);
  logic [NUM_FIELDS-1:0] used;
  logic [NUM_FIELDS-1:0] equal;

  assign used = compare_set(rpt_i);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    localparam logic [DATA_W-1:0] MASK = DATA_W'(field_mask(i));
    assign equal[i] = ((alarm_i[i] ^ now_i[i]) & MASK) == '0;
  end

  assign hit_o = tick_i && ((equal | ~used) == '1);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  hit_i,
  input  logic  rd_i,
  input  logic  ptr_at_flag_i,
  input  logic  on_battery_i,
  input  ctrl_t ctrl_i,
  output logic  flag_o,
  output logic  irq_no
);
  logic af_q, af_d;
  logic pend_q, pend_d;
  logic irq_n_q, irq_n_d;
  logic gate;

  // interrupt permission at the moment of a match
  always_comb begin
    gate = ctrl_i.irq_en && !ctrl_i.wave_en;
    if (on_battery_i) gate = gate && ctrl_i.bkp_en;
  end

  always_comb begin
    af_d    = (af_q && !rd_i) || hit_i;
    pend_d  = (pend_q && !rd_i) || (hit_i && gate);
    irq_n_d = !(pend_d && !ptr_at_flag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_q    <= 1'b0;
      pend_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      af_q    <= af_d;
      pend_q  <= pend_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign flag_o = af_q;
  assign irq_no = irq_n_q;

  // R8: flag can only rise after a tick
  p_flag_needs_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (af_q && !$past(af_q)) |-> $past(tick_i));

  // R4: interrupt active implies flag set
  p_irq_implies_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_n_q |-> af_q);

  // R6: pointer on flags location keeps interrupt inactive
  p_ptr_holds_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ptr_at_flag_i) |-> irq_n_q);

  // R5: a read without a match clears flag and interrupt
  p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_i) && !$past(hit_i)) |-> (!af_q && irq_n_q));

  // R7: on battery without backup enable a match cannot raise a new interrupt
  p_backup_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && on_battery_i && !ctrl_i.bkp_en && !pend_q) |=> irq_n_q);
endmodule

// File: rtl/alarm_calendar_unit.sv
module alarm_calendar_unit
  import alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic [DATA_W-1:0] now_sec_i,
  input  logic [DATA_W-1:0] now_min_i,
  input  logic [DATA_W-1:0] now_hr_i,
  input  logic [DATA_W-1:0] now_date_i,
  input  logic [DATA_W-1:0] now_mon_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              flag_rd_i,
  input  logic              ptr_at_flag_i,
  input  logic              on_battery_i,
  output logic              alarm_flag_o,
  output logic              irq_no
);
  logic [1:0]                        rst_sync_q;
  logic                              rst_n;
  ctrl_t                             ctrl;
  logic [RPT_W-1:0]                  rpt;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] now;
  logic                              hit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign now = {now_mon_i, now_date_i, now_hr_i, now_min_i, now_sec_i};

  alarm_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl),
    .alarm_o (alarm),
    .rpt_o   (rpt)
  );

  alarm_match #(.DATA_W(DATA_W)) u_match (
    .tick_i  (sec_tick_i),
    .rpt_i   (rpt),
    .alarm_i (alarm),
    .now_i   (now),
    .hit_o   (hit)
  );

  alarm_irq_ctrl u_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .tick_i        (sec_tick_i),
    .hit_i         (hit),
    .rd_i          (flag_rd_i),
    .ptr_at_flag_i (ptr_at_flag_i),
    .on_battery_i  (on_battery_i),
    .ctrl_i        (ctrl),
    .flag_o        (alarm_flag_o),
    .irq_no        (irq_no)
  );

  // R2: no tick, no match
  p_hit_only_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit |-> sec_tick_i);
endmodule

// File: tb/alarm_calendar_unit_test.sv
module alarm_calendar_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       d_tick = 0, d_we = 0, d_rd = 0, d_ptr = 0, d_bkp = 0;
  logic [2:0] d_sel = 0;
  logic [7:0] d_wdata = 0;
  logic [7:0] d_now [5];
  logic       af_o, irq_o;

  alarm_calendar_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(d_tick),
    .now_sec_i(d_now[0]), .now_min_i(d_now[1]), .now_hr_i(d_now[2]),
    .now_date_i(d_now[3]), .now_mon_i(d_now[4]),
    .reg_we_i(d_we), .reg_sel_i(d_sel), .reg_wdata_i(d_wdata),
    .flag_rd_i(d_rd), .ptr_at_flag_i(d_ptr), .on_battery_i(d_bkp),
    .alarm_flag_o(af_o), .irq_no(irq_o)
  );

  // bench model state
  logic [2:0] m_ctrl;
  logic [4:0] m_rpt;
  logic [7:0] m_alarm [5];
  logic       m_af, m_pend, m_irq_n;
  int         n_vec = 0, n_bad = 0;
  string      cur_req = "R1";

  function automatic logic [7:0] mask_of(int i);
    return (i < 2) ? 8'h7F : (i < 4) ? 8'h3F : 8'h1F;
  endfunction

  function automatic int fields_used(logic [4:0] c);
    case (c)
      5'b11110: return 1;
      5'b11100: return 2;
      5'b11000: return 3;
      5'b10000: return 4;
      5'b00000: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic logic exp_hit();
    logic h = d_tick;
    for (int i = 0; i < fields_used(m_rpt); i++)
      if (((m_alarm[i] ^ d_now[i]) & mask_of(i)) != 0) h = 0;
    return h;
  endfunction

  function automatic logic [7:0] to_bcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic model_reset();
    m_ctrl = 0; m_rpt = 0; m_af = 0; m_pend = 0; m_irq_n = 1;
    for (int i = 0; i < 5; i++) m_alarm[i] = 0;
  endtask

  task automatic check_out();
    n_vec++;
    if (af_o !== m_af || irq_o !== m_irq_n) begin
      n_bad++;
      $display("FAIL %s: flag/irq_n actual %b/%b expected %b/%b", cur_req, af_o, irq_o, m_af, m_irq_n);
    end
  endtask

  // one clock: model updates with the driven inputs, then outputs compared
  task automatic step();
    logic h, g;
    @(posedge clk);
    h = exp_hit();
    g = m_ctrl[0] && !m_ctrl[2] && (!d_bkp || m_ctrl[1]);
    m_af    = (m_af && !d_rd) || h;
    m_pend  = (m_pend && !d_rd) || (h && g);
    m_irq_n = !(m_pend && !d_ptr);
    if (d_we) begin
      if (d_sel == 0) m_ctrl = d_wdata[2:0];
      else if (d_sel == 6) m_rpt = d_wdata[4:0];
      else if (d_sel <= 5) m_alarm[d_sel-1] = d_wdata;
    end
    #1;
    check_out();
    d_tick = 0; d_we = 0; d_rd = 0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    d_we = 1; d_sel = sel; d_wdata = data; step();
  endtask

  task automatic set_now(input logic [7:0] s, mi, h, dt, mo);
    d_now[0] = s; d_now[1] = mi; d_now[2] = h; d_now[3] = dt; d_now[4] = mo;
  endtask

  task automatic tick_at(input logic [7:0] s, mi, h, dt, mo);
    set_now(s, mi, h, dt, mo); d_tick = 1; step();
  endtask

  task automatic rd_flags(); d_rd = 1; step(); endtask

  task automatic load_alarm(input logic [7:0] s, mi, h, dt, mo);
    wr(3'd1, s); wr(3'd2, mi); wr(3'd3, h); wr(3'd4, dt); wr(3'd5, mo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    set_now(0, 0, 0, 8'h01, 8'h01);
    model_reset();
    repeat (3) @(posedge clk);
    #1 cur_req = "R1"; check_out();
    rst_n = 1;
    repeat (3) step();

    // R9 register layout; alarm 12:34:56 on day 15 of month 7
    cur_req = "R9";
    wr(3'd0, 8'h01);
    load_alarm(8'h56, 8'h34, 8'h12, 8'h15, 8'h07);

    // R2 yearly: all fields must match
    cur_req = "R2"; wr(3'd6, 8'h00);
    tick_at(8'h56, 8'h34, 8'h12, 8'h15, 8'h08);   // month differs
    tick_at(8'h56, 8'h34, 8'h12, 8'h15, 8'h07);   // full match
    rd_flags(); step();
    // R2 monthly ignores month
    wr(3'd6, 8'h10);
    tick_at(8'h56, 8'h34, 8'h12, 8'h15, 8'h02); rd_flags();
    tick_at(8'h56, 8'h34, 8'h12, 8'h16, 8'h07); step();
    // R2 daily, hourly, per-minute
    wr(3'd6, 8'h18);
    tick_at(8'h56, 8'h34, 8'h12, 8'h01, 8'h01); rd_flags();
    tick_at(8'h56, 8'h34, 8'h13, 8'h15, 8'h07); step();
    wr(3'd6, 8'h1C);
    tick_at(8'h56, 8'h34, 8'h09, 8'h03, 8'h03); rd_flags();
    tick_at(8'h56, 8'h35, 8'h12, 8'h15, 8'h07); step();
    wr(3'd6, 8'h1E);
    tick_at(8'h56, 8'h00, 8'h00, 8'h01, 8'h01); rd_flags();
    tick_at(8'h57, 8'h34, 8'h12, 8'h15, 8'h07); step();
    // R2 every second
    wr(3'd6, 8'h1F);
    tick_at(8'h01, 8'h02, 8'h03, 8'h04, 8'h05); rd_flags();

    // R3 unlisted codes act as every second
    cur_req = "R3";
    wr(3'd6, 8'h15);
    tick_at(8'h09, 8'h09, 8'h09, 8'h09, 8'h09); rd_flags();
    wr(3'd6, 8'h01);
    tick_at(8'h10, 8'h11, 8'h12, 8'h13, 8'h11); rd_flags();

    // R4 flag without interrupt when disabled or square wave on
    cur_req = "R4";
    wr(3'd0, 8'h00); tick_at(0, 0, 0, 1, 1); rd_flags();
    wr(3'd0, 8'h05); tick_at(0, 0, 0, 1, 1); rd_flags();
    wr(3'd0, 8'h01); tick_at(0, 0, 0, 1, 1);

    // R5 read clears; read and match together keep the flag
    cur_req = "R5";
    rd_flags(); step();
    tick_at(0, 0, 0, 1, 1);
    d_rd = 1; d_tick = 1; step();
    rd_flags();

    // R6 pointer on flags location holds the interrupt off
    cur_req = "R6";
    d_ptr = 1; tick_at(0, 0, 0, 1, 1); step();
    d_ptr = 0; step(); step();
    d_ptr = 1; step(); rd_flags();
    d_ptr = 0; step();

    // R7 backup mode needs both enables
    cur_req = "R7";
    d_bkp = 1; tick_at(0, 0, 0, 1, 1); rd_flags();
    wr(3'd0, 8'h03); tick_at(0, 0, 0, 1, 1); rd_flags();
    d_bkp = 0;

    // R8 matching time without tick does nothing
    cur_req = "R8";
    wr(3'd0, 8'h01); wr(3'd6, 8'h1E);
    set_now(8'h56, 0, 0, 1, 1); step(); step();
    tick_at(8'h56, 0, 0, 1, 1); rd_flags(); step(); step();

    // R9 bits above each BCD field are ignored
    cur_req = "R9";
    wr(3'd6, 8'h00);
    load_alarm(8'hD6, 8'hB4, 8'hD2, 8'hD5, 8'hE7);
    tick_at(8'h56, 8'h34, 8'h12, 8'h15, 8'h07); rd_flags();
    tick_at(8'hD6, 8'hB4, 8'hD2, 8'hD5, 8'hE8); step();

    // random mix
    cur_req = "R2";
    begin
      int unsigned seed;
      logic [4:0] codes [6];
      logic [7:0] base [5];
      seed = $urandom(32'd2718);
      codes[0] = 5'b11111; codes[1] = 5'b11110; codes[2] = 5'b11100;
      codes[3] = 5'b11000; codes[4] = 5'b10000; codes[5] = 5'b00000;
      for (int blk = 0; blk < 40; blk++) begin
        base[0] = to_bcd($urandom_range(59));
        base[1] = to_bcd($urandom_range(59));
        base[2] = to_bcd($urandom_range(23));
        base[3] = to_bcd($urandom_range(31, 1));
        base[4] = to_bcd($urandom_range(12, 1));
        load_alarm(base[0], base[1], base[2], base[3], base[4]);
        wr(3'd6, ($urandom_range(3) == 0) ? 8'($urandom_range(31)) : {3'b0, codes[$urandom_range(5)]});
        wr(3'd0, 8'($urandom_range(7)));
        for (int k = 0; k < 30; k++) begin
          for (int f = 0; f < 5; f++)
            d_now[f] = ($urandom_range(3) == 0) ? to_bcd($urandom_range(12, 1)) : base[f];
          d_tick = ($urandom_range(1) == 1);
          d_rd   = ($urandom_range(5) == 0);
          d_ptr  = ($urandom_range(7) == 0);
          d_bkp  = ($urandom_range(5) == 0);
          step();
        end
      end
      d_ptr = 0; d_bkp = 0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule